// File: doc/BRIEF.md
# Dual 24-bit Down-Counting Timer

A register-mapped peripheral holding two independent 24-bit down counters. Each channel owns a control word, which packs count enable, interrupt enable, operating mode and a clock prescale value, and an initial count register. A shared status register collects one expiry flag per channel. Software clears a flag by writing a one to its bit.

Each channel decrements once every prescale+1 input clocks. When it reaches zero it raises its flag. In periodic mode it then reloads and keeps running. In one-shot mode it stops and hardware clears its enable bit. Channel 1 also exposes its live count through a read-only data register, so it can serve as a free-running time base. Channel 0 typically serves as the event timer.

The bus is a single-cycle interface. A write takes effect at the clock edge where `we_i` is high. Read data is a combinational function of `addr_i`. The interrupt output combines both channels.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, both control words read 0x00000001 (the prescale field resets to 1, all else 0). Initial counts (0x8, 0xC), the channel-1 data register (0x14) and the status register (0x18) read 0. `irq_o` is low.
- R2: A control write that sets bit 30 (enable) while the channel is stopped loads the counter from its initial count register. Initial counts store only bits 23:0, so the largest value is 0xFFFFFF. The channel-1 data register at 0x14 returns the live count in bits 23:0, with the upper bits zero.
- R3: While enabled, a channel decrements once every P+1 clocks, where P is control bits 7:0. The first decrement lands P+1 edges after the enabling edge.
- R4: Writing bit 30 to 0 freezes the count. It does not change while the channel stays disabled.
- R5: A channel reaches zero N×(P+1) edges after enabling with initial count N (an initial count of 0 behaves as 1). At that edge it sets its status flag: bit 0 for channel 0 (control at 0x0, count at 0x8), bit 1 for channel 1 (control at 0x4, count at 0xC).
- R6: With mode bits 28:27 = 01 (periodic), expiry reloads the counter from the initial count. The counter keeps running, and the flag sets again every N×(P+1) edges.
- R7: With any other mode value (00 is the normal one-shot), expiry leaves the count at 0 and hardware clears bit 30. The other control fields keep their values.
- R8: Writing an initial count while the channel runs does not alter the current count. The new value is used at the next reload.
- R9: Writing the status register clears each flag whose data bit is 1 and leaves flags written with 0. Writing 0x1F clears all. If a channel expires in the same cycle its flag is being cleared, the flag ends set.
- R10: `irq_o` is high exactly when some channel has its flag set and its bit 29 (interrupt enable) set.
- R11: The two channels count, expire and flag independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, takes effect at the rising edge |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a software write-one-to-clear on the status register, and a hardware expiry setting the same flag. The bench runs channel 1 in periodic mode with prescale 0 and a known period. It counts edges from the enabling write, then times a status write so that its edge is the expiry edge. The flag must read set afterwards, and the other channel's flag must remain clear. A clear on a non-expiry edge is checked beside it, to show the clear itself works.

// File: rtl/ddt_pkg.sv
package ddt_pkg;
  localparam int unsigned OFF_CTRL0 = 'h00;
  localparam int unsigned OFF_CTRL1 = 'h04;
  localparam int unsigned OFF_INIT0 = 'h08;
  localparam int unsigned OFF_INIT1 = 'h0C;
  localparam int unsigned OFF_LIVE1 = 'h14;
  localparam int unsigned OFF_STAT  = 'h18;

  localparam int unsigned BIT_EN    = 30;
  localparam int unsigned BIT_IE    = 29;
  localparam int unsigned BIT_MODEH = 28;
  localparam int unsigned BIT_MODEL = 27;

  localparam logic [1:0] MODE_PERIODIC = 2'b01;
endpackage

// File: rtl/ddt_prescaler.sv
module ddt_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  // >= keeps the divider sane if the prescale shrinks mid-run
  assign tick_o = run_i && (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clear_i) div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else if (run_i)   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ddt_channel.sv
module ddt_channel
  import ddt_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned PSC_W   = 8,
  parameter int unsigned PSC_RST = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             wr_en_i,
  input  logic             wr_ie_i,
  input  logic [1:0]       wr_mode_i,
  input  logic [PSC_W-1:0] wr_psc_i,
  input  logic [CNT_W-1:0] init_i,
  output logic             en_o,
  output logic             ie_o,
  output logic [1:0]       mode_o,
  output logic [PSC_W-1:0] psc_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             periodic_o,
  output logic             tick_o,
  output logic             expire_o
);
  logic start;

  assign start      = ctrl_we_i && wr_en_i && !en_o;
  assign periodic_o = (mode_o == MODE_PERIODIC);
  assign expire_o   = tick_o && (cnt_o <= CNT_W'(1));

  ddt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_o),
    .clear_i(start),
    .psc_i  (psc_o),
    .tick_o (tick_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o   <= 1'b0;
      mode_o <= '0;
      psc_o  <= PSC_W'(PSC_RST);
    end else if (ctrl_we_i) begin
      ie_o   <= wr_ie_i;
      mode_o <= wr_mode_i;
      psc_o  <= wr_psc_i;
    end
  end

  // software write wins over the one-shot self-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      en_o <= 1'b0;
    else if (ctrl_we_i)               en_o <= wr_en_i;
    else if (expire_o && !periodic_o) en_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (start)    cnt_o <= init_i;
    else if (expire_o) cnt_o <= periodic_o ? init_i : '0;
    else if (tick_o)   cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import ddt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned PSC_W   = 8,
  parameter int unsigned PSC_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned NCH = 2;

  logic [NCH-1:0]            ctrl_we;
  logic [NCH-1:0]            init_we;
  logic                      stat_we;
  logic [NCH-1:0]            en_w, ie_w, periodic_w, tick_w, expire_w;
  logic [NCH-1:0][1:0]       mode_w;
  logic [NCH-1:0][PSC_W-1:0] psc_w;
  logic [NCH-1:0][CNT_W-1:0] cnt_w;
  logic [NCH-1:0][CNT_W-1:0] init_q;
  logic [NCH-1:0]            flag_q;

  assign ctrl_we[0] = we_i && (addr_i == ADDR_W'(OFF_CTRL0));
  assign ctrl_we[1] = we_i && (addr_i == ADDR_W'(OFF_CTRL1));
  assign init_we[0] = we_i && (addr_i == ADDR_W'(OFF_INIT0));
  assign init_we[1] = we_i && (addr_i == ADDR_W'(OFF_INIT1));
  assign stat_we    = we_i && (addr_i == ADDR_W'(OFF_STAT));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ddt_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W), .PSC_RST(PSC_RST)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (ctrl_we[c]),
      .wr_en_i   (wdata_i[BIT_EN]),
      .wr_ie_i   (wdata_i[BIT_IE]),
      .wr_mode_i (wdata_i[BIT_MODEH:BIT_MODEL]),
      .wr_psc_i  (wdata_i[PSC_W-1:0]),
      .init_i    (init_q[c]),
      .en_o      (en_w[c]),
      .ie_o      (ie_w[c]),
      .mode_o    (mode_w[c]),
      .psc_o     (psc_w[c]),
      .cnt_o     (cnt_w[c]),
      .periodic_o(periodic_w[c]),
      .tick_o    (tick_w[c]),
      .expire_o  (expire_w[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         init_q[c] <= '0;
      else if (init_we[c]) init_q[c] <= wdata_i[CNT_W-1:0];
    end

    // hardware set dominates a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      flag_q[c] <= 1'b0;
      else if (expire_w[c])             flag_q[c] <= 1'b1;
      else if (stat_we && wdata_i[c])   flag_q[c] <= 1'b0;
    end
  end

  assign irq_o = |(flag_q & ie_w);

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic en, input logic ie,
                                                  input logic [1:0] md,
                                                  input logic [PSC_W-1:0] ps);
    logic [DATA_W-1:0] r;
    r = '0;
    r[BIT_EN]              = en;
    r[BIT_IE]              = ie;
    r[BIT_MODEH:BIT_MODEL] = md;
    r[PSC_W-1:0]           = ps;
    return r;
  endfunction

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_CTRL0): rdata_o = pack_ctrl(en_w[0], ie_w[0], mode_w[0], psc_w[0]);
      ADDR_W'(OFF_CTRL1): rdata_o = pack_ctrl(en_w[1], ie_w[1], mode_w[1], psc_w[1]);
      ADDR_W'(OFF_INIT0): rdata_o[CNT_W-1:0] = init_q[0];
      ADDR_W'(OFF_INIT1): rdata_o[CNT_W-1:0] = init_q[1];
      ADDR_W'(OFF_LIVE1): rdata_o[CNT_W-1:0] = cnt_w[1];
      ADDR_W'(OFF_STAT):  rdata_o[NCH-1:0]   = flag_q;
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ddt_checker.sv
module ddt_checker #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned NCH   = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NCH-1:0]            ctrl_we,
  input logic                      stat_we,
  input logic [31:0]               wdata_i,
  input logic [NCH-1:0]            en_w,
  input logic [NCH-1:0]            ie_w,
  input logic [NCH-1:0]            periodic_w,
  input logic [NCH-1:0]            tick_w,
  input logic [NCH-1:0]            expire_w,
  input logic [NCH-1:0]            flag_q,
  input logic [NCH-1:0][CNT_W-1:0] cnt_w,
  input logic [NCH-1:0][CNT_W-1:0] init_q,
  input logic                      irq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_w[c]) |-> cnt_w[c] == $past(init_q[c]));
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_w[c] && !tick_w[c] && !ctrl_we[c]) |=> $stable(cnt_w[c]));
    p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_w[c] && !ctrl_we[c]) |=> $stable(cnt_w[c]));
    p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_w[c] |=> flag_q[c]);
    p_oneshot_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_w[c] && !periodic_w[c] && !ctrl_we[c]) |=> (!en_w[c] && cnt_w[c] == '0));
    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[c] && !(stat_we && wdata_i[c])) |=> flag_q[c]);
  end

  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & ie_w) == '0) |-> !irq_o);
  p_irq_raise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & ie_w) != '0) |-> irq_o);
endmodule

bind dual_down_timer ddt_checker #(.CNT_W(CNT_W), .NCH(2)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_we   (ctrl_we),
  .stat_we   (stat_we),
  .wdata_i   (wdata_i),
  .en_w      (en_w),
  .ie_w      (ie_w),
  .periodic_w(periodic_w),
  .tick_w    (tick_w),
  .expire_w  (expire_w),
  .flag_q    (flag_q),
  .cnt_w     (cnt_w),
  .init_q    (init_q),
  .irq_o     (irq_o)
);

// File: tb/sim_dual_down_timer.sv
`timescale 1ns/1ps
module sim_dual_down_timer;
  localparam logic [4:0] A_C0 = 5'h00, A_C1 = 5'h04, A_I0 = 5'h08,
                         A_I1 = 5'h0C, A_D1 = 5'h14, A_ST = 5'h18;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_down_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] ctrl_word(bit en, bit ie, logic [1:0] md, logic [7:0] ps);
    return {1'b0, en, ie, md, 19'd0, ps};
  endfunction

  function automatic int expiry_edges(int n, int p);
    return ((n == 0) ? 1 : n) * (p + 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(logic [4:0] a, logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [31:0] v;
    int n, p, e;
    logic [1:0] md;
    void'($urandom(32'h1A2B3C4D));

    #35 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    rd(A_C0, v); chk("R1 ctrl0", v, 32'h1);
    rd(A_C1, v); chk("R1 ctrl1", v, 32'h1);
    rd(A_I0, v); chk("R1 init0", v, 0);
    rd(A_I1, v); chk("R1 init1", v, 0);
    rd(A_D1, v); chk("R1 live1", v, 0);
    rd(A_ST, v); chk("R1 status", v, 0);
    chk("R1 irq", irq_o, 0);

    // R2 load on enable, R3 P=0 rate, R4 freeze
    wr(A_I1, 20);
    wr(A_C1, ctrl_word(1, 0, 2'b00, 0));
    rd(A_D1, v); chk("R2 load", v, 20);
    wait_edges(5);
    rd(A_D1, v); chk("R3 p0 rate", v, 15);
    wr(A_C1, ctrl_word(0, 0, 2'b00, 0));
    rd(A_D1, v); chk("R4 last tick", v, 14);
    wait_edges(10);
    rd(A_D1, v); chk("R4 frozen", v, 14);

    // R3 random prescale
    for (int i = 0; i < 4; i++) begin
      n = 10 + int'($urandom_range(50));
      p = 1 + int'($urandom_range(5));
      wr(A_C1, 0);
      wr(A_I1, n);
      wr(A_C1, ctrl_word(1, 0, 2'b00, p[7:0]));
      wait_edges(3 * (p + 1) - 1);
      rd(A_D1, v); chk("R3 before tick", v, n - 2);
      wait_edges(1);
      rd(A_D1, v); chk("R3 on tick", v, n - 3);
    end
    wr(A_C1, 0);

    // R5 / R7 / R10 random one-shot expiry on channel 0
    for (int i = 0; i < 4; i++) begin
      n  = int'($urandom_range(6));
      p  = int'($urandom_range(3));
      md = $urandom_range(1) ? 2'b11 : 2'b00;
      wr(A_ST, 32'h1F);
      wr(A_I0, n);
      wr(A_C0, ctrl_word(1, 1, md, p[7:0]));
      e = expiry_edges(n, p);
      wait_edges(e - 1);
      rd(A_ST, v); chk("R5 not yet", v, 0);
      chk("R10 irq low", irq_o, 0);
      wait_edges(1);
      rd(A_ST, v); chk("R5 flag", v, 1);
      chk("R10 irq high", irq_o, 1);
      rd(A_C0, v); chk("R7 en cleared", v, ctrl_word(0, 1, md, p[7:0]));
    end

    // R9 partial and full clear
    wr(A_ST, 32'h2);
    rd(A_ST, v); chk("R9 zero bit keeps", v, 1);
    wr(A_ST, 32'h1F);
    rd(A_ST, v); chk("R9 clear all", v, 0);
    chk("R10 irq after clear", irq_o, 0);

    // R10 gating by interrupt enable
    wr(A_I0, 2);
    wr(A_C0, ctrl_word(1, 0, 2'b00, 0));
    wait_edges(2);
    rd(A_ST, v); chk("R10 flag no ie", v, 1);
    chk("R10 gated", irq_o, 0);
    wr(A_C0, ctrl_word(0, 1, 2'b00, 0));
    chk("R10 ie on", irq_o, 1);
    wr(A_ST, 32'h1);

    // R6 periodic on channel 1, period 4
    wr(A_I1, 4);
    wr(A_C1, ctrl_word(1, 0, 2'b01, 0));
    wait_edges(4);
    rd(A_ST, v); chk("R6 first expiry", v, 2);
    rd(A_D1, v); chk("R6 reload", v, 4);
    wr(A_ST, 32'h2);
    rd(A_ST, v); chk("R9 clear off-edge", v, 0);
    rd(A_D1, v); chk("R6 running", v, 3);
    wait_edges(3);
    rd(A_ST, v); chk("R6 second expiry", v, 2);
    rd(A_C1, v); chk("R6 still enabled", v, ctrl_word(1, 0, 2'b01, 0));

    // R8 initial count changed while running
    wr(A_I1, 7);
    rd(A_D1, v); chk("R8 current kept", v, 3);
    wait_edges(3);
    rd(A_D1, v); chk("R8 new reload", v, 7);

    // R9 clear coinciding with expiry, R11 other channel untouched
    wait_edges(6);
    wr(A_ST, 32'h2);
    rd(A_ST, v); chk("R9 set wins R11", v, 2);
    rd(A_D1, v); chk("R6 reload after collision", v, 7);

    // R2 width limit
    wr(A_C1, 0);
    wr(A_I1, 32'hFFFF_FFFF);
    rd(A_I1, v); chk("R2 init width", v, 32'h00FF_FFFF);
    wr(A_C1, ctrl_word(1, 0, 2'b00, 0));
    rd(A_D1, v); chk("R2 max load", v, 32'h00FF_FFFF);
    wait_edges(1);
    rd(A_D1, v); chk("R2 max decrement", v, 32'h00FF_FFFE);

    done = 1'b1;
    finish_up();
  end
endmodule